// File: doc/BRIEF.md
# Vectored external interrupt controller

This block collects a set of level-sensitive interrupt request lines and presents a single interrupt to a processor's external interrupt port. For every source, software sets an enable bit, a priority level, a shadow register set number and a non-maskable flag over a small register bus. Software also sets one common handler base address. Each cycle in which nothing is being presented, the block picks the strongest eligible source. It then latches that source's bundle: a request strobe, a handler address, a register set number, the source level and a non-maskable flag.

A source that is not non-maskable is eligible only when its level is strictly above the current level that the processor reports. A non-maskable source is always eligible, and it beats every maskable source. Among sources of the same kind, the higher level wins, and a tie goes to the lower index. The handler address is the base plus the source index times 32. The bundle stays fixed until the processor pulses acknowledge. The strobe then drops for one cycle, and the block arbitrates again on the following clock.

Register map: address 0 holds the 32-bit handler base. Address 1+i holds the word for source i. In that word, bit 0 is enable and bit 1 is non-maskable. Bits 5:2 hold the level and bits 11:6 hold the register set. All other bits read as zero. Reads are combinational. Addresses above the source count read as zero and ignore writes.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every source reads back as disabled, maskable, level 0 and register set 0. The base reads 0 and the request output is low.
- R2: A write to address 0 sets the handler base. A write to address 1+i sets source i's fields (bit 0 enable, bit 1 non-maskable, bits 5:2 level, bits 11:6 register set). Every field reads back at the same address.
- R3: A source is pending only while its request line is high and its enable bit is set. A disabled source is never presented.
- R4: A maskable source is presented only if its level is strictly greater than the current level input.
- R5: Among eligible maskable sources, the highest level wins. Equal levels go to the lower source index.
- R6: A non-maskable source is eligible at any current level and beats every maskable source. The non-maskable output is high exactly when such a source is presented.
- R7: The bundle carries the handler address, which is base plus 32 times the source index. It also carries the winning source's register set and level.
- R8: While the request is high and no acknowledge has come, the request and every bundle field stay unchanged. This holds even when the inputs, the current level or the configuration change.
- R9: An acknowledge while the request is high drives the request low on the next clock. On the clock after that, arbitration runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive request lines, one per source |
| cur_lvl | input | 4 | Processor's current interrupt level |
| irq_ack | input | 1 | One-cycle acknowledge of the presented interrupt |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| irq_req | output | 1 | Interrupt request strobe, held until acknowledged |
| irq_vec | output | 32 | Handler address of the presented source |
| irq_rs | output | 6 | Register set number of the presented source |
| irq_lvl | output | 4 | Level of the presented source |
| irq_nmi | output | 1 | Presented source is non-maskable |

## Verification
The checker assumes that acknowledge is only meaningful while the request is high. It also assumes that the current level and the request lines are sampled at the clock edge that latches a winner, so the level and priority properties compare against those sampled values. The bench drives every input on the falling edge, so the values are settled at each rising edge. It pulses acknowledge for one cycle and only while a request is shown. It also changes the lines, the current level and the configuration during a held request, which tests the stability property against real input activity.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC   = 32,
  parameter int LVLW   = 4,
  parameter int RSW    = 6,
  parameter int VECW   = 32,
  parameter int VSPACE = 32,
  localparam int IDW    = $clog2(NSRC),
  localparam int AW     = $clog2(NSRC + 1),
  localparam int VSHIFT = $clog2(VSPACE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [LVLW-1:0] cur_lvl,
  input  logic            irq_ack,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [VECW-1:0] cfg_wdata,
  output logic [VECW-1:0] cfg_rdata,
  output logic            irq_req,
  output logic [VECW-1:0] irq_vec,
  output logic [RSW-1:0]  irq_rs,
  output logic [LVLW-1:0] irq_lvl,
  output logic            irq_nmi
);
  localparam int LPOS = 2;
  localparam int RPOS = 2 + LVLW;

  logic [NSRC-1:0] en_q, nmi_q;
  logic [LVLW-1:0] lvl_q [NSRC];
  logic [RSW-1:0]  rs_q  [NSRC];
  logic [VECW-1:0] base_q;

  wire            src_hit = (cfg_addr != '0) && (cfg_addr <= AW'(NSRC));
  wire [IDW-1:0]  src_sel = IDW'(cfg_addr - AW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      nmi_q  <= '0;
      base_q <= '0;
      for (int i = 0; i < NSRC; i++) begin
        lvl_q[i] <= '0;
        rs_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr == '0) base_q <= cfg_wdata;
      else if (src_hit) begin
        en_q[src_sel]  <= cfg_wdata[0];
        nmi_q[src_sel] <= cfg_wdata[1];
        lvl_q[src_sel] <= cfg_wdata[LPOS +: LVLW];
        rs_q[src_sel]  <= cfg_wdata[RPOS +: RSW];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == '0) cfg_rdata = base_q;
    else if (src_hit) begin
      cfg_rdata[0]             = en_q[src_sel];
      cfg_rdata[1]             = nmi_q[src_sel];
      cfg_rdata[LPOS +: LVLW]  = lvl_q[src_sel];
      cfg_rdata[RPOS +: RSW]   = rs_q[src_sel];
    end
  end

  logic            win_hit, win_nmi;
  logic [LVLW-1:0] win_lvl;
  logic [IDW-1:0]  win_id;

  always_comb begin
    win_hit = 1'b0;
    win_nmi = 1'b0;
    win_lvl = '0;
    win_id  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (irq_in[i] && en_q[i] && (nmi_q[i] || lvl_q[i] > cur_lvl)) begin
        if (!win_hit || {nmi_q[i], lvl_q[i]} > {win_nmi, win_lvl}) begin
          win_hit = 1'b1;
          win_nmi = nmi_q[i];
          win_lvl = lvl_q[i];
          win_id  = IDW'(i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_rs  <= '0;
      irq_lvl <= '0;
      irq_nmi <= 1'b0;
    end else if (irq_req) begin
      if (irq_ack) irq_req <= 1'b0;
    end else if (win_hit) begin
      irq_req <= 1'b1;
      irq_vec <= base_q + (VECW'(win_id) << VSHIFT);
      irq_rs  <= rs_q[win_id];
      irq_lvl <= win_lvl;
      irq_nmi <= win_nmi;
    end
  end
endmodule

module vec_irq_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int LVLW = 4,
  parameter int RSW  = 6,
  parameter int VECW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_in,
  input logic [LVLW-1:0] cur_lvl,
  input logic            irq_ack,
  input logic            irq_req,
  input logic [VECW-1:0] irq_vec,
  input logic [RSW-1:0]  irq_rs,
  input logic [LVLW-1:0] irq_lvl,
  input logic            irq_nmi,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] nmi_q
);
  a_r8_hold_bundle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec) && $stable(irq_rs)
                            && $stable(irq_lvl) && $stable(irq_nmi));

  a_r9_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack |=> !irq_req);

  a_r4_level_above: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) && !irq_nmi |-> irq_lvl > $past(cur_lvl));

  a_r6_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) && !irq_nmi |-> $past((irq_in & en_q & nmi_q) == '0));

  a_r3_some_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past((irq_in & en_q) != '0));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NSRC(NSRC), .LVLW(LVLW), .RSW(RSW), .VECW(VECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cur_lvl(cur_lvl), .irq_ack(irq_ack),
  .irq_req(irq_req), .irq_vec(irq_vec), .irq_rs(irq_rs), .irq_lvl(irq_lvl),
  .irq_nmi(irq_nmi), .en_q(en_q), .nmi_q(nmi_q)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [3:0]  cur_lvl = '0;
  logic        irq_ack = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, irq_vec;
  logic        irq_req, irq_nmi;
  logic [5:0]  irq_rs;
  logic [3:0]  irq_lvl;

  vec_irq_ctrl i_vec_irq_ctrl (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] base = '0;
  logic        m_en [32], m_nmi [32];
  logic [3:0]  m_lvl [32];
  logic [5:0]  m_rs [32];

  localparam logic [41:0] TBL [11] = '{
    {32'h0000_0088, 4'd0,  1'b1, 5'd3},
    {32'h0000_0408, 4'd0,  1'b1, 5'd10},
    {32'h8000_0400, 4'd0,  1'b1, 5'd31},
    {32'h0010_0000, 4'd2,  1'b0, 5'd0},
    {32'h0010_0000, 4'd1,  1'b1, 5'd20},
    {32'h8000_1000, 4'd15, 1'b1, 5'd12},
    {32'h0000_0020, 4'd0,  1'b0, 5'd0},
    {32'h8000_0000, 4'd15, 1'b0, 5'd0},
    {32'h0000_0408, 4'd5,  1'b1, 5'd10},
    {32'h0000_0088, 4'd5,  1'b0, 5'd0},
    {32'h8000_1088, 4'd0,  1'b1, 5'd12}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic en, input logic nmi, input logic [3:0] lvl,
                                       input logic [5:0] rs);
    return {20'b0, rs, lvl, nmi, en};
  endfunction

  task automatic wr_src(input int i, input logic en, input logic nmi, input logic [3:0] lvl,
                        input logic [5:0] rs);
    cfg_we = 1'b1; cfg_addr = 6'(i + 1); cfg_wdata = pack(en, nmi, lvl, rs);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    m_en[i] = en; m_nmi[i] = nmi; m_lvl[i] = lvl; m_rs[i] = rs;
  endtask

  task automatic wr_base(input logic [31:0] b);
    cfg_we = 1'b1; cfg_addr = 6'd0; cfg_wdata = b;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0; base = b;
  endtask

  task automatic check_bundle(input string tag, input int id);
    check({tag, " vec"}, irq_vec, base + 32'(id) * 32);
    check({tag, " rs"},  32'(irq_rs),  32'(m_rs[id]));
    check({tag, " lvl"}, 32'(irq_lvl), 32'(m_lvl[id]));
    check({tag, " nmi"}, 32'(irq_nmi), 32'(m_nmi[id]));
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_en[i] = 0; m_nmi[i] = 0; m_lvl[i] = 0; m_rs[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req", 32'(irq_req), 0);
    cfg_addr = 6'd0;  #0.1 check("R1 base", cfg_rdata, 0);
    cfg_addr = 6'd1;  #0.1 check("R1 src0", cfg_rdata, 0);
    cfg_addr = 6'd32; #0.1 check("R1 src31", cfg_rdata, 0);
    irq_in = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk);
    check("R3 all disabled", 32'(irq_req), 0);
    irq_in = '0;

    wr_base(32'h1000_0000);
    wr_src(3,  1, 0, 4'd5,  6'd2);
    wr_src(7,  1, 0, 4'd5,  6'd3);
    wr_src(10, 1, 0, 4'd9,  6'd4);
    wr_src(20, 1, 0, 4'd2,  6'd1);
    wr_src(31, 1, 0, 4'd15, 6'd63);
    wr_src(12, 1, 1, 4'd0,  6'd7);
    wr_src(5,  0, 0, 4'd14, 6'd9);
    cfg_addr = 6'd32; #0.1 check("R2 src31 readback", cfg_rdata, pack(1, 0, 15, 63));
    cfg_addr = 6'd13; #0.1 check("R2 src12 readback", cfg_rdata, pack(1, 1, 0, 7));
    cfg_addr = 6'd6;  #0.1 check("R2 src5 readback",  cfg_rdata, pack(0, 0, 14, 9));
    cfg_addr = 6'd0;  #0.1 check("R2 base readback",  cfg_rdata, 32'h1000_0000);

    // R3 R4 R5 R6 R7 table walk
    for (int k = 0; k < 11; k++) begin
      irq_in = TBL[k][41:10]; cur_lvl = TBL[k][9:6];
      @(posedge clk); @(negedge clk);
      check($sformatf("R4/R5/R6 row%0d req", k), 32'(irq_req), 32'(TBL[k][5]));
      if (TBL[k][5]) begin
        check_bundle($sformatf("R7 row%0d", k), int'(TBL[k][4:0]));
        irq_in = '0;
        ack_pulse();
        check($sformatf("R9 row%0d drop", k), 32'(irq_req), 0);
      end else irq_in = '0;
      @(posedge clk); @(negedge clk);
    end

    // R8 hold while inputs and configuration move
    irq_in = 32'h0000_0400; cur_lvl = 4'd0;
    @(posedge clk); @(negedge clk);
    check("R8 present", 32'(irq_req), 1);
    irq_in = 32'h8000_1000; cur_lvl = 4'd15;
    wr_src(10, 1, 0, 4'd1, 6'd40);
    wr_base(32'h3000_0000);
    check("R8 req held", 32'(irq_req), 1);
    check("R8 vec held", irq_vec, 32'h1000_0000 + 10 * 32);
    check("R8 rs held",  32'(irq_rs), 4);
    check("R8 lvl held", 32'(irq_lvl), 9);
    check("R8 nmi held", 32'(irq_nmi), 0);
    wr_src(10, 1, 0, 4'd9, 6'd4);
    wr_base(32'h1000_0000);

    // R9 re-arbitration with the line still high
    irq_in = 32'h0000_0400; cur_lvl = 4'd0;
    ack_pulse();
    check("R9 low after ack", 32'(irq_req), 0);
    @(posedge clk); @(negedge clk);
    check("R9 rearbitrated", 32'(irq_req), 1);
    check_bundle("R9 rearb", 10);
    irq_in = '0;
    ack_pulse();

    // R7 new base
    wr_base(32'h2000_0040);
    irq_in = 32'h0010_0000;
    @(posedge clk); @(negedge clk);
    check("R7 base move req", 32'(irq_req), 1);
    check("R7 base move vec", irq_vec, 32'h2000_02C0);
    irq_in = '0;
    ack_pulse();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule